// File: doc/BRIEF.md
# Bus Handoff Arbiter with Flush Handshake

This block arbitrates a shared expansion bus that normally belongs to a bridge. When a secondary master or the refresh engine wants the bus, the block raises a hold request toward the bridge. It then waits for the hold acknowledge before it hands the bus on.

A master cycle might cross the bridge, so the bridge's posted buffers are flushed first. The flush uses one active-low, pulled-up, bidirectional line that both parties can drive. The arbiter pulls the line low for a single clock and then releases it. The bridge holds the line low while it drains its buffers, and then drives it high for one clock. When the arbiter samples that high level, it drives the line high again. On that same edge it grants the bus to the lowest-index master that is requesting at that moment.

A refresh cycle never goes to the far side of the bridge, so it skips the flush. Once the refresh ends, the bus always returns to the bridge. While hold acknowledge is high, the bridge can ask for the bus back. The arbiter then withdraws the grant and drops the hold request once the master lets go.

Top module: `bus_handoff_arb`

## Requirements
- R1: Reset state: hold request low, no master grant, no refresh grant, and the flush line driven high (enable 1, value 1).
- R2: From idle, a master or refresh request sampled on an edge raises the hold request right after that edge. Refresh takes precedence when both are present.
- R3: No grant appears before hold acknowledge. The first edge that samples hold acknowledge high starts a flush request: the flush drive is enabled with value 0 for exactly one clock, and the drive is disabled after that.
- R4: While the line is released, the grant is withheld until the arbiter has sampled the line low and then high. After the edge that samples it high, the line is driven high again (enable 1, value 1).
- R5: The grant issued on that closing edge is one-hot. It goes to the lowest-index master requesting on that same edge (bit i of the grant vector means master i).
- R6: For a refresh, the edge that samples hold acknowledge raises the refresh grant. The line stays driven high and no master is granted.
- R7: After the refresh request drops, the next edge removes the refresh grant and drops the hold request. No master is granted, even if masters are requesting.
- R8: While the owner keeps requesting, its grant and the hold request stay high. The edge that samples the owner's request low removes the grant and drops the hold request.
- R9: If the bridge request is high together with hold acknowledge while a master owns the bus, the next edge removes the grant. The hold request stays high until the owner's request is sampled low.
- R10: After the hold request drops, no new hold request is raised until hold acknowledge has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mst_req_i | input | N_MST | Bus requests from secondary masters |
| mst_gnt_o | output | N_MST | One-hot grant to secondary masters |
| rfsh_req_i | input | 1 | Refresh engine request |
| rfsh_gnt_o | output | 1 | Refresh engine grant |
| hold_o | output | 1 | Hold request to the bridge |
| hlda_i | input | 1 | Hold acknowledge from the bridge |
| brg_req_i | input | 1 | Bridge asks for the bus back |
| flush_oe_o | output | 1 | Flush line drive enable |
| flush_do_o | output | 1 | Flush line drive value |
| flush_di_i | input | 1 | Sampled level of the flush line |

## Verification
None of the outputs depends combinationally on an input, so every result is due exactly one edge after the stimulus that causes it. This holds for hold request, flush drive, grant and grant removal alike. The bench changes inputs 1 ns after a rising edge and reads the outputs at that same point after the next edge. Each check therefore sees the state that single edge produced. The flush sequence is stepped edge by edge: the pulse cycle, the release, a randomly delayed low phase from the bridge model and the one-clock high phase. The bench checks the grant on the edge after the high phase, against a request pattern that was changed just before it.

// File: rtl/bha_pkg.sv
`timescale 1ns/1ps
package bha_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_FL_PULSE, ST_FL_WAIT,
    ST_OWN, ST_PREEMPT, ST_RFSH, ST_RELEASE
  } bha_state_e;
endpackage

// File: rtl/bha_prio_pick.sv
`timescale 1ns/1ps
module bha_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign win_o[i] = req_i[i];
    end else begin : g_rest
      assign win_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/bha_flush_port.sv
`timescale 1ns/1ps
module bha_flush_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,  // drive low this cycle
  input  logic wait_i,   // line released, waiting for bridge
  input  logic line_i,
  output logic oe_o,
  output logic do_o,
  output logic done_o
);
  logic seen_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_low_q <= 1'b0;
    else if (!wait_i) seen_low_q <= 1'b0;
    else if (!line_i) seen_low_q <= 1'b1;
  end

  assign oe_o   = ~wait_i;
  assign do_o   = ~pulse_i;
  // closes only on a high sample that follows a low one
  assign done_o = wait_i & seen_low_q & line_i;
endmodule

// File: rtl/bus_handoff_arb.sv
`timescale 1ns/1ps
module bus_handoff_arb
  import bha_pkg::*;
#(
  parameter int N_MST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] mst_req_i,
  output logic [N_MST-1:0] mst_gnt_o,
  input  logic             rfsh_req_i,
  output logic             rfsh_gnt_o,
  output logic             hold_o,
  input  logic             hlda_i,
  input  logic             brg_req_i,
  output logic             flush_oe_o,
  output logic             flush_do_o,
  input  logic             flush_di_i
);
  bha_state_e       state_q, state_d;
  logic             rfsh_q, rfsh_d;
  logic [N_MST-1:0] own_q, own_d;
  logic [N_MST-1:0] win;
  logic             any_req, fl_done, own_req;

  bha_prio_pick #(.N(N_MST)) u_pick (
    .req_i (mst_req_i),
    .win_o (win),
    .any_o (any_req)
  );

  bha_flush_port u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(state_q == ST_FL_PULSE),
    .wait_i (state_q == ST_FL_WAIT),
    .line_i (flush_di_i),
    .oe_o   (flush_oe_o),
    .do_o   (flush_do_o),
    .done_o (fl_done)
  );

  assign own_req = |(own_q & mst_req_i);

  always_comb begin
    state_d = state_q;
    rfsh_d  = rfsh_q;
    own_d   = own_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rfsh_req_i || any_req) begin
          state_d = ST_HOLD;
          rfsh_d  = rfsh_req_i;
        end
      end
      ST_HOLD:     if (hlda_i) state_d = rfsh_q ? ST_RFSH : ST_FL_PULSE;
      ST_FL_PULSE: state_d = ST_FL_WAIT;
      ST_FL_WAIT: begin
        if (fl_done) begin
          state_d = any_req ? ST_OWN : ST_RELEASE;
          own_d   = win;
        end
      end
      ST_OWN: begin
        if (!own_req)                state_d = ST_RELEASE;
        else if (brg_req_i && hlda_i) state_d = ST_PREEMPT;
      end
      ST_PREEMPT:  if (!own_req) state_d = ST_RELEASE;
      ST_RFSH:     if (!rfsh_req_i) state_d = ST_RELEASE;
      ST_RELEASE:  if (!hlda_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rfsh_q  <= 1'b0;
      own_q   <= '0;
    end else begin
      state_q <= state_d;
      rfsh_q  <= rfsh_d;
      own_q   <= own_d;
    end
  end

  assign mst_gnt_o  = (state_q == ST_OWN) ? own_q : '0;
  assign rfsh_gnt_o = (state_q == ST_RFSH);
  assign hold_o     = (state_q != ST_IDLE) && (state_q != ST_RELEASE);
endmodule

// File: rtl/bha_checker.sv
`timescale 1ns/1ps
module bha_checker #(
  parameter int N_MST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] mst_req_i,
  input logic [N_MST-1:0] mst_gnt_o,
  input logic             rfsh_gnt_o,
  input logic             hold_o,
  input logic             hlda_i,
  input logic             brg_req_i,
  input logic             flush_oe_o,
  input logic             flush_do_o,
  input logic             flush_di_i
);
  logic fl_low;
  assign fl_low = flush_oe_o & ~flush_do_o;

  a_r3_gnt_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mst_gnt_o) |-> hold_o);
  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_low |=> !fl_low);
  a_r4_gnt_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|mst_gnt_o) |-> ($past(flush_di_i) && flush_oe_o && flush_do_o));
  a_r5_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mst_gnt_o));
  a_r6_rfsh_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_gnt_o |-> (!fl_low && mst_gnt_o == '0));
  a_r8_owner_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(mst_gnt_o & ~mst_req_i)) |=> (mst_gnt_o == '0));
  a_r9_bridge_takes_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brg_req_i && hlda_i && |mst_gnt_o) |=> (mst_gnt_o == '0));
  a_r10_wait_hlda_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && hlda_i) |=> !hold_o);
endmodule

bind bus_handoff_arb bha_checker #(.N_MST(N_MST)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mst_req_i  (mst_req_i),
  .mst_gnt_o  (mst_gnt_o),
  .rfsh_gnt_o (rfsh_gnt_o),
  .hold_o     (hold_o),
  .hlda_i     (hlda_i),
  .brg_req_i  (brg_req_i),
  .flush_oe_o (flush_oe_o),
  .flush_do_o (flush_do_o),
  .flush_di_i (flush_di_i)
);

// File: tb/sim_bus_handoff_arb.sv
`timescale 1ns/1ps
module sim_bus_handoff_arb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] mst_req = '0;
  logic [N-1:0] mst_gnt;
  logic         rfsh_req = 1'b0, rfsh_gnt;
  logic         hold, hlda = 1'b0, brg_req = 1'b0;
  logic         fl_oe, fl_do, fl_line;
  logic         br_oe = 1'b0, br_do = 1'b1;
  int           n_run = 0, n_fail = 0;
  bit           finished = 0;

  always #10 clk = ~clk;

  // wired line: pulled up, low if any party drives low
  assign fl_line = !((fl_oe && !fl_do) || (br_oe && !br_do));

  bus_handoff_arb #(.N_MST(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mst_req_i(mst_req), .mst_gnt_o(mst_gnt),
    .rfsh_req_i(rfsh_req), .rfsh_gnt_o(rfsh_gnt), .hold_o(hold), .hlda_i(hlda),
    .brg_req_i(brg_req), .flush_oe_o(fl_oe), .flush_do_o(fl_do), .flush_di_i(fl_line)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic mst_txn(input logic [N-1:0] req0, input logic [N-1:0] late,
                         input int hl_dly, input int br_dly, input int fl_len,
                         input int own_len, input bit preempt);
    mst_req = req0;
    step();
    chk("R2 hold up", 32'(hold), 1);
    for (int i = 0; i < hl_dly; i++) begin
      step();
      chk("R3 no gnt before hlda", 32'(mst_gnt), 0);
      chk("R3 line high before hlda", 32'({fl_oe, fl_do}), 32'b11);
    end
    hlda = 1'b1;
    step();
    chk("R3 flush pulse", 32'({fl_oe, fl_do}), 32'b10);
    step();
    chk("R3 line released", 32'(fl_oe), 0);
    for (int i = 0; i < br_dly; i++) begin
      step();
      chk("R4 no gnt without low phase", 32'(mst_gnt), 0);
    end
    br_oe = 1'b1; br_do = 1'b0;
    for (int i = 0; i < fl_len; i++) begin
      step();
      chk("R4 no gnt while flushing", 32'(mst_gnt), 0);
      chk("R4 still released", 32'(fl_oe), 0);
    end
    br_do = 1'b1;
    mst_req = late;
    step();
    br_oe = 1'b0;
    chk("R5 winner on closing edge", 32'(mst_gnt), 32'(lowest(late)));
    chk("R4 line driven high", 32'({fl_oe, fl_do}), 32'b11);
    for (int i = 0; i < own_len; i++) begin
      step();
      chk("R8 grant held", 32'({hold, mst_gnt}), 32'({1'b1, lowest(late)}));
    end
    if (preempt) begin
      brg_req = 1'b1;
      step();
      chk("R9 grant removed", 32'(mst_gnt), 0);
      chk("R9 hold kept", 32'(hold), 1);
      step();
      chk("R9 hold kept while owner busy", 32'(hold), 1);
    end
    mst_req = '0;
    step();
    chk("R8 release on drop", 32'({hold, mst_gnt}), 0);
    mst_req = late;
    step();
    chk("R10 no hold while hlda high", 32'(hold), 0);
    hlda = 1'b0; mst_req = '0; brg_req = 1'b0;
    step();
    step();
    chk("R10 idle", 32'(hold), 0);
  endtask

  task automatic rfsh_txn(input logic [N-1:0] req, input int hl_dly, input int len);
    rfsh_req = 1'b1; mst_req = req;
    step();
    chk("R2 hold for refresh", 32'(hold), 1);
    for (int i = 0; i < hl_dly; i++) step();
    hlda = 1'b1;
    step();
    chk("R6 refresh grant", 32'(rfsh_gnt), 1);
    for (int i = 0; i < len; i++) begin
      chk("R6 no flush, no master", 32'({fl_oe, fl_do, mst_gnt}), 32'({2'b11, N'(0)}));
      step();
    end
    rfsh_req = 1'b0;
    step();
    chk("R7 back to bridge", 32'({hold, rfsh_gnt, mst_gnt}), 0);
    step();
    chk("R7 no master after refresh", 32'({hold, mst_gnt}), 0);
    hlda = 1'b0; mst_req = '0;
    step();
    step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    #35 rst_n = 1'b1;
    step();
    chk("R1 reset state", 32'({hold, mst_gnt, rfsh_gnt, fl_oe, fl_do}), 32'b11);
    // directed corners
    mst_txn(4'b1000, 4'b0110, 0, 0, 1, 0, 1'b0);
    mst_txn(4'b0001, 4'b1001, 3, 2, 4, 2, 1'b1);
    mst_txn(4'b0100, 4'b1100, 1, 1, 2, 1, 1'b0);
    rfsh_txn(4'b0011, 1, 2);
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] a, b;
      a = N'($urandom_range(1, (1 << N) - 1));
      b = N'($urandom_range(1, (1 << N) - 1));
      if ($urandom_range(0, 4) == 0)
        rfsh_txn(a, $urandom_range(0, 3), $urandom_range(1, 4));
      else
        mst_txn(a, b, $urandom_range(0, 3), $urandom_range(0, 2),
                $urandom_range(1, 5), $urandom_range(0, 4), 1'($urandom_range(0, 1)));
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule